// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block provides three independent periodic timers behind one synchronous register port. Each channel owns a down-counter, a reload constant and a control register. Every channel derives its count ticks from the system clock through its own prescaler. When a tick arrives while the counter already reads zero, the counter takes the constant again and keeps running. The same tick also latches a sticky underflow flag. Software starts and stops the channels through one shared start register that has one run bit per channel.

An interrupt line per channel stays high while that channel's flag and its interrupt enable are both set. Software therefore has to clear the flag, by writing 0 to its bit, before it re-enables or returns from the handler. Software can also preload the counter with a first count that differs from the reload constant. This gives a first interval of one length followed by a regular period of constant + 1 ticks.

Top module: `reload_timer`

## Requirements
- R1: After reset every counter and every constant reads 0xFFFFFFFF, and every control register, the start register and `irq_o` read 0.
- R2: Start-register bit i (address 0, bits 2:0, other bits ignored) enables channel i. A channel whose bit is 0 holds its count, and the other channels are not affected.
- R3: Prescale field code 0, 1, 2 or 3 (control bits 2:0) gives one tick per 4, 16, 64 or 256 system clocks. Codes 4 to 7 behave as code 0. A stopped channel's prescaler is cleared, so the first tick comes the chosen number of clocks after the start-bit write takes effect.
- R4: A tick taken while the counter is 0 loads the constant, sets the flag and counting continues. Any other tick decrements the counter. The steady repeat period is the constant + 1 ticks.
- R5: The counter register is writable at any time. A counter write in the same cycle as a tick takes the written value, and that tick is dropped.
- R6: The underflow flag (control bit 8) is sticky. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R7: When a flag-clearing write and an underflow fall in the same cycle, the flag ends up set.
- R8: `irq_o[i]` is high exactly while channel i's flag and its interrupt enable (control bit 5) are both 1.
- R9: Channel i has its control register at word address 1+3i, its constant at 2+3i and its counter at 3+3i. Unused control bits read 0, and addresses 10 to 15 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe, taken at the clock edge |
| reg_addr_i | input | 4 | Word address for both reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 3 | Per-channel interrupt request, level |

## Verification
A software write to a control register can land in the same cycle as an underflow tick of that channel. A counter write can also land in the same cycle as an ordinary tick. The bench counts clock edges from the edge that set the start bit and works out in advance on which edge each tick falls. It then times a flag-clearing write, and separately a counter write, to land exactly on that edge. The flag must read set after the collision and clear after a second, tick-free clear. The counter must show the written value and then decrement from it four clocks later.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int unsigned N_CH        = 3;
  localparam int unsigned CNT_W       = 32;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned PSC_W       = 3;
  localparam int unsigned PS_W        = 8;
  localparam int unsigned PSC_LSB     = 0;
  localparam int unsigned EN_BIT      = 5;
  localparam int unsigned FLAG_BIT    = 8;
  localparam int unsigned START_ADDR  = 0;
  localparam int unsigned CH_BASE     = 1;
  localparam int unsigned REGS_PER_CH = 3;
  localparam int unsigned OFS_CTRL    = 0;
  localparam int unsigned OFS_CONST   = 1;
  localparam int unsigned OFS_COUNT   = 2;

  typedef struct packed {
    logic             flag;
    logic             en;
    logic [PSC_W-1:0] psc;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PSC_LSB +: PSC_W] = c.psc;
    w[EN_BIT]           = c.en;
    w[FLAG_BIT]         = c.flag;
    return w;
  endfunction

  // low-bit mask of the prescaler for one tick per 4/16/64/256 clocks
  function automatic logic [PS_W-1:0] div_mask(logic [PSC_W-1:0] code);
    logic [PS_W-1:0] m;
    case (code)
      3'd1:    m = PS_W'(8'h0F);
      3'd2:    m = PS_W'(8'h3F);
      3'd3:    m = PS_W'(8'hFF);
      default: m = PS_W'(8'h03);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rtmr_prescaler.sv
module rtmr_prescaler
  import rtmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  always_comb mask = div_mask(psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && ((cnt_q & mask) == mask);

  a_r3_clear_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
  a_r3_min_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rtmr_channel.sv
module rtmr_channel
  import rtmr_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ctrl_we_i,
  input  logic              const_we_i,
  input  logic              cnt_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [CW-1:0]     const_o,
  output logic [CW-1:0]     cnt_o,
  output logic              irq_o
);
  logic          tick;
  logic          underflow;
  logic [CW-1:0] cnt_q, const_q;
  ctrl_t         ctrl_q;

  rtmr_prescaler u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .psc_i  (ctrl_q.psc),
    .tick_o (tick)
  );

  // a counter write drops a coincident tick
  assign underflow = tick && (cnt_q == '0) && !cnt_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i[CW-1:0];
    end else if (tick) begin
      cnt_q <= underflow ? const_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         const_q <= '1;
    else if (const_we_i) const_q <= wdata_i[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        ctrl_q.psc <= wdata_i[PSC_LSB +: PSC_W];
        ctrl_q.en  <= wdata_i[EN_BIT];
      end
      if (underflow)                             ctrl_q.flag <= 1'b1;
      else if (ctrl_we_i && !wdata_i[FLAG_BIT])  ctrl_q.flag <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign const_o = const_q;
  assign cnt_o   = cnt_q;
  assign irq_o   = ctrl_q.flag && ctrl_q.en;

  a_r2_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q));
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q == '0 && !cnt_we_i) |=> cnt_q == $past(const_q));
  a_r4_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q != '0 && !cnt_we_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r5_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(wdata_i[CW-1:0]));
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.flag && !(ctrl_we_i && !wdata_i[FLAG_BIT])) |=> ctrl_q.flag);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wdata_i[FLAG_BIT] && !underflow) |=> !ctrl_q.flag);
  a_r7_uf_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q == '0 && !cnt_we_i) |=> ctrl_q.flag);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtmr_pkg::*;
#(
  parameter int unsigned NCH = N_CH,
  parameter int unsigned CW  = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int unsigned LAST_ADDR = CH_BASE + REGS_PER_CH * NCH - 1;

  logic [NCH-1:0] start_q;
  ctrl_t          ctrl_w  [NCH];
  logic [CW-1:0]  const_w [NCH];
  logic [CW-1:0]  cnt_w   [NCH];
  logic           start_we;

  assign start_we = reg_we_i && (reg_addr_i == ADDR_W'(START_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       start_q <= '0;
    else if (start_we) start_q <= reg_wdata_i[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned BASE = CH_BASE + REGS_PER_CH * c;
    rtmr_channel #(.CW(CW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (start_q[c]),
      .ctrl_we_i  (reg_we_i && reg_addr_i == ADDR_W'(BASE + OFS_CTRL)),
      .const_we_i (reg_we_i && reg_addr_i == ADDR_W'(BASE + OFS_CONST)),
      .cnt_we_i   (reg_we_i && reg_addr_i == ADDR_W'(BASE + OFS_COUNT)),
      .wdata_i    (reg_wdata_i),
      .ctrl_o     (ctrl_w[c]),
      .const_o    (const_w[c]),
      .cnt_o      (cnt_w[c]),
      .irq_o      (irq_o[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(START_ADDR)) reg_rdata_o = DATA_W'(start_q);
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr_i == ADDR_W'(CH_BASE + REGS_PER_CH * i + OFS_CTRL))
        reg_rdata_o = ctrl_to_word(ctrl_w[i]);
      if (reg_addr_i == ADDR_W'(CH_BASE + REGS_PER_CH * i + OFS_CONST))
        reg_rdata_o = DATA_W'(const_w[i]);
      if (reg_addr_i == ADDR_W'(CH_BASE + REGS_PER_CH * i + OFS_COUNT))
        reg_rdata_o = DATA_W'(cnt_w[i]);
    end
  end

  a_r2_start_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_we |=> $stable(start_q));
  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i > ADDR_W'(LAST_ADDR)) |-> reg_rdata_o == '0);
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reload_timer dut (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_o (irq)
  );

  // {address, write data, expected read-back}
  localparam logic [67:0] VEC [7] = '{
    {4'd4,  32'hFFFF_FFFF, 32'h0000_0027},
    {4'd5,  32'h1234_5678, 32'h1234_5678},
    {4'd9,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {4'd7,  32'h0000_0003, 32'h0000_0003},
    {4'd0,  32'hFFFF_FFF8, 32'h0000_0000},
    {4'd15, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd10, 32'h0000_0055, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ps_case(input logic [2:0] code, input int n);
    logic [31:0] d;
    wr(4'd0, 32'h0); wr(4'd1, {29'h0, code}); wr(4'd2, 32'h0); wr(4'd3, 32'h0);
    wr(4'd0, 32'h1);
    wt(n - 1); rd(4'd1, d); chk("R3 no tick yet", {31'h0, d[8]}, 32'h0);
    wt(1);     rd(4'd1, d); chk("R3 tick due", {31'h0, d[8]}, 32'h1);
  endtask

  initial begin
    logic [31:0] seq [6];
    seq = '{32'd1, 32'd0, 32'd2, 32'd1, 32'd0, 32'd2};
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    wt(3); rst_n = 1'b1; wt(1);

    // R1 reset state
    chk("R1 irq", {29'h0, irq}, 32'h0);
    chk_rd("R1 start", 4'd0, 32'h0);
    for (int c = 0; c < 3; c++) begin
      chk_rd("R1 ctrl", 4'(1 + 3 * c), 32'h0);
      chk_rd("R1 const", 4'(2 + 3 * c), 32'hFFFF_FFFF);
      chk_rd("R1 count", 4'(3 + 3 * c), 32'hFFFF_FFFF);
    end

    // R9 / R6 register map table
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      chk_rd("R9 map", VEC[i][67:64], VEC[i][31:0]);
    end
    chk("R8 enable without flag", {29'h0, irq}, 32'h0);

    // R4 reload and period const+1, R2 start
    wr(4'd1, 32'h0); wr(4'd2, 32'd2); wr(4'd3, 32'd1); wr(4'd0, 32'h1);
    chk_rd("R2 count at start", 4'd3, seq[0]);
    for (int k = 1; k < 6; k++) begin
      wt(3); chk_rd("R4 before tick", 4'd3, seq[k-1]);
      wt(1); chk_rd("R4 after tick", 4'd3, seq[k]);
    end
    chk_rd("R4 flag set", 4'd1, 32'h100);
    chk("R8 flag without enable", {29'h0, irq}, 32'h0);
    chk_rd("R2 other channel idle", 4'd9, 32'hDEAD_BEEF);
    wr(4'd0, 32'h0);
    wt(10); chk_rd("R2 stopped holds", 4'd3, 32'd2);

    // R7 clear colliding with underflow, R6 clean clear
    wr(4'd1, 32'h0); wr(4'd2, 32'h0); wr(4'd3, 32'h0); wr(4'd0, 32'h1);
    wt(4); chk_rd("R4 underflow at zero", 4'd1, 32'h100);
    wt(3); wr(4'd1, 32'h0);
    chk_rd("R7 underflow wins", 4'd1, 32'h100);
    wr(4'd1, 32'h0);
    chk_rd("R6 clear", 4'd1, 32'h0);
    wr(4'd0, 32'h0);

    // R5 counter write beats tick
    wr(4'd1, 32'h0); wr(4'd2, 32'd9); wr(4'd3, 32'd5); wr(4'd0, 32'h1);
    wt(3); wr(4'd3, 32'd7);
    chk_rd("R5 write wins", 4'd3, 32'd7);
    wt(4); chk_rd("R5 counts from written", 4'd3, 32'd6);

    // R3 prescale codes
    ps_case(3'd1, 16);
    ps_case(3'd2, 64);
    ps_case(3'd3, 256);
    ps_case(3'd5, 4);
    ps_case(3'd7, 4);
    ps_case(3'd0, 4);

    // R3 prescaler cleared by stop
    wr(4'd0, 32'h0); wr(4'd1, 32'h0); wr(4'd2, 32'h0); wr(4'd3, 32'd10);
    wr(4'd0, 32'h1);
    wt(2); wr(4'd0, 32'h0); wr(4'd0, 32'h1);
    wt(3); chk_rd("R3 restart no early tick", 4'd3, 32'd10);
    wt(1); chk_rd("R3 restart tick", 4'd3, 32'd9);

    // R2 independence
    wr(4'd0, 32'h0); wr(4'd4, 32'h0); wr(4'd6, 32'd3); wr(4'd3, 32'd8);
    wr(4'd0, 32'h2);
    wt(4);
    chk_rd("R2 ch1 runs", 4'd6, 32'd2);
    chk_rd("R2 ch0 held", 4'd3, 32'd8);
    wr(4'd0, 32'h0);

    // R8 interrupt level
    wr(4'd7, 32'h20); wr(4'd8, 32'd3); wr(4'd9, 32'h0);
    chk("R8 idle", {29'h0, irq}, 32'h0);
    wr(4'd0, 32'h4);
    wt(3); chk("R8 before underflow", {29'h0, irq}, 32'h0);
    wt(1); chk("R8 raised", {29'h0, irq}, 32'h4);
    chk_rd("R4 reload ch2", 4'd9, 32'd3);
    wr(4'd0, 32'h0);
    chk("R8 level persists", {29'h0, irq}, 32'h4);
    wr(4'd7, 32'h100);
    chk("R8 disabled", {29'h0, irq}, 32'h0);
    chk_rd("R6 write one keeps", 4'd7, 32'h100);
    wr(4'd7, 32'h120);
    chk("R8 re-enable repeats", {29'h0, irq}, 32'h4);
    wr(4'd7, 32'h20);
    chk("R8 cleared", {29'h0, irq}, 32'h0);
    chk_rd("R6 cleared ctrl", 4'd7, 32'h20);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule